// File: doc/BRIEF.md
# Accumulator Register-Op, I/O and Interrupt Controller

This block is the execution slice of a small 16-bit accumulator processor that handles every instruction with no memory operand, and the interrupt entry sequence. A surrounding fetch and memory-reference engine supplies the instruction word, the current value of the sequence counter, the accumulator, the extend bit E and the 8-bit input character. At sequence step 3 the block decodes a register-operation word (top nibble 0111) or a device word (top nibble 1111). It drives the new accumulator and E values with write enables, asks for the program counter to be bumped when a skip condition holds, and asks for the sequence counter to be cleared.

The block owns the machine's control flip-flops: halt, interrupt enable, interrupt request, input-ready and output-ready. It also owns the 8-bit output character register. Devices report a new input character with a strobe and a finished output with a done pulse. When the interrupt request is pending, steps 0 to 2 are taken over by a three-step entry sequence. That sequence saves the program counter at word 0 and resumes at word 1. The block produces the strobes for it.

Top module: `accum_regio_ctrl`

## Requirements
- R1: An instruction executes only when `step` equals 3, `ir_word[15:12]` is 0111 (register class) or 1111 (device class), the machine is not halted and no interrupt is pending. In that cycle `seq_clr` is 1. Any other opcode or step produces no write enable, no `pc_inc` and no `seq_clr`.
- R2: For register words, bit 11 loads AC with 0 and bit 10 loads E with 0. Bit 9 loads AC with its one's complement and bit 8 inverts E. The matching write enable is high in the same cycle.
- R3: Register bit 7 rotates E:AC right: AC becomes {E, AC[15:1]} and E becomes AC[0]. Bit 6 rotates left: AC becomes {AC[14:0], E} and E becomes AC[15]. Both AC and E write enables are high.
- R4: Register bit 5 loads AC with AC+1, wrapping from FFFF to 0000, and leaves `e_wr` low.
- R5: Register bits 4, 3, 2 and 1 raise `pc_inc` in the execution cycle when, respectively, AC[15] is 0, AC[15] is 1, AC is zero, or E is 0.
- R6: Register bit 0 sets `halted` from the next cycle on. Only reset clears it, and while it is set no instruction executes.
- R7: Device bit 11 loads AC with {AC[15:8], `in_char`} and clears `in_flag` after the cycle. Device bit 10 copies AC[7:0] into `out_char` and clears `out_flag` after the cycle.
- R8: A high `in_strobe` sets `in_flag` and a high `out_done` sets `out_flag`. A strobe in the same cycle as the clearing instruction wins, so the flag ends up set.
- R9: Device bit 9 raises `pc_inc` when `in_flag` is 1, and device bit 8 does so when `out_flag` is 1.
- R10: Device bit 7 sets `irq_en` and device bit 6 clears it, both taking effect after the cycle.
- R11: `irq_req` becomes 1 after a cycle in which `step` is greater than 2, `irq_en` is 1 and at least one of `in_flag` and `out_flag` is 1. A cycle with `step` 0, 1 or 2 never sets it.
- R12: While `irq_req` is 1, step 0 raises `ar_clr` and `tr_ld_pc`, step 1 raises `mem_wr` and `pc_clr`, and step 2 raises `pc_inc` and `seq_clr`. After step 2, `irq_req` and `irq_en` are both 0.
- R13: After reset, `halted`, `irq_en`, `irq_req`, `in_flag` and `out_flag` are 0 and `out_char` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_word | input | 16 | Current instruction word |
| step | input | 4 | Current sequence-counter value |
| acc_in | input | 16 | Current accumulator |
| e_in | input | 1 | Current extend bit |
| in_char | input | 8 | Character held by the input register |
| in_strobe | input | 1 | Device has placed a new input character |
| out_done | input | 1 | Output device has finished and is ready |
| acc_nxt | output | 16 | New accumulator value |
| acc_wr | output | 1 | Load `acc_nxt` into AC |
| e_nxt | output | 1 | New extend bit |
| e_wr | output | 1 | Load `e_nxt` into E |
| pc_inc | output | 1 | Increment the program counter (skip or interrupt step 2) |
| seq_clr | output | 1 | Clear the sequence counter |
| ar_clr | output | 1 | Interrupt step 0: clear the address register |
| tr_ld_pc | output | 1 | Interrupt step 0: copy PC into the temporary register |
| mem_wr | output | 1 | Interrupt step 1: write the temporary register to memory |
| pc_clr | output | 1 | Interrupt step 1: clear the program counter |
| out_char | output | 8 | Output character register |
| in_flag | output | 1 | Input character ready |
| out_flag | output | 1 | Output device ready |
| irq_en | output | 1 | Interrupt enable |
| irq_req | output | 1 | Interrupt request pending |
| halted | output | 1 | Machine halted |

## Verification
The hardest state to reach from the ports is a pending interrupt. It needs the enable set by an instruction, a device flag raised by a strobe, and a later cycle at a step above 2, all without the flag being consumed first. The stimulus gets there in a fixed order. It enables interrupts while both flags are clear, then raises the input flag through the same cycle as a consuming input instruction, and shows that a step-0 cycle does not set the request. Only then does it present a step above 2 and walk the three entry steps. Random one-hot register words with random accumulator values, some of them forced to zero, cover the data-path and skip cases.

// File: rtl/accum_regio_pkg.sv
package accum_regio_pkg;

    localparam int DATA_W    = 16;
    localparam int CHAR_W    = 8;
    localparam int STEP_W    = 4;
    localparam int OPS_W     = 12;
    localparam int EXEC_STEP = 3;

    // register-class bit positions within the low operation field
    localparam int RB_CLR_AC  = 11;
    localparam int RB_CLR_E   = 10;
    localparam int RB_CPL_AC  = 9;
    localparam int RB_CPL_E   = 8;
    localparam int RB_ROT_R   = 7;
    localparam int RB_ROT_L   = 6;
    localparam int RB_INC     = 5;
    localparam int RB_SK_POS  = 4;
    localparam int RB_SK_NEG  = 3;
    localparam int RB_SK_ZERO = 2;
    localparam int RB_SK_E0   = 1;
    localparam int RB_HALT    = 0;

    // device-class operations use the upper six bits of the field
    localparam int IO_BASE = 6;
    localparam int IO_W    = OPS_W - IO_BASE;
    localparam int IB_IN   = 11 - IO_BASE;
    localparam int IB_OUT  = 10 - IO_BASE;
    localparam int IB_SKI  = 9 - IO_BASE;
    localparam int IB_SKO  = 8 - IO_BASE;
    localparam int IB_ION  = 7 - IO_BASE;
    localparam int IB_IOF  = 6 - IO_BASE;

    typedef enum logic [1:0] {
        CLS_OTHER = 2'd0,
        CLS_REG   = 2'd1,
        CLS_DEV   = 2'd2
    } instr_cls_e;

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic              e;
        logic              acc_wr;
        logic              e_wr;
    } acc_upd_t;

    function automatic instr_cls_e classify(input logic [DATA_W-1:0] w);
        instr_cls_e c;
        c = CLS_OTHER;
        if (w[DATA_W-2 -: 3] == 3'b111)
            c = w[DATA_W-1] ? CLS_DEV : CLS_REG;
        return c;
    endfunction

endpackage

// File: rtl/accum_regop_unit.sv
module accum_regop_unit
    import accum_regio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [OPS_W-1:0]  ops,
    input  logic [DATA_W-1:0] acc,
    input  logic              e,
    output acc_upd_t          upd,
    output logic              skip,
    output logic              halt_req
);

    logic [DATA_W-1:0] a;
    logic              x;
    logic              tmp;

    // operations applied as a chain so the result of one feeds the next
    always_comb begin
        a   = acc;
        x   = e;
        tmp = 1'b0;
        if (ops[RB_CLR_AC]) a = '0;
        if (ops[RB_CLR_E])  x = 1'b0;
        if (ops[RB_CPL_AC]) a = ~a;
        if (ops[RB_CPL_E])  x = ~x;
        if (ops[RB_ROT_R]) begin
            tmp = a[0];
            a   = {x, a[DATA_W-1:1]};
            x   = tmp;
        end
        if (ops[RB_ROT_L]) begin
            tmp = a[DATA_W-1];
            a   = {a[DATA_W-2:0], x};
            x   = tmp;
        end
        if (ops[RB_INC]) a = a + DATA_W'(1);

        upd.acc    = a;
        upd.e      = x;
        upd.acc_wr = go & (ops[RB_CLR_AC] | ops[RB_CPL_AC] | ops[RB_ROT_R] |
                           ops[RB_ROT_L]  | ops[RB_INC]);
        upd.e_wr   = go & (ops[RB_CLR_E] | ops[RB_CPL_E] | ops[RB_ROT_R] |
                           ops[RB_ROT_L]);
    end

    assign skip = go & ((ops[RB_SK_POS]  & ~acc[DATA_W-1]) |
                        (ops[RB_SK_NEG]  &  acc[DATA_W-1]) |
                        (ops[RB_SK_ZERO] & (acc == '0))    |
                        (ops[RB_SK_E0]   & ~e));

    assign halt_req = go & ops[RB_HALT];

    // R4: increment alone never touches E
    a_r4_inc_keeps_e: assert property (@(posedge clk) disable iff (rst)
        (go && ops == OPS_W'(1 << RB_INC)) |-> !upd.e_wr);

    // R3: a lone right rotate moves AC bit 0 into E
    a_r3_rot_right_e: assert property (@(posedge clk) disable iff (rst)
        (go && ops == OPS_W'(1 << RB_ROT_R)) |-> (upd.e == acc[0]));

endmodule

// File: rtl/accum_io_unit.sv
module accum_io_unit
    import accum_regio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [IO_W-1:0]   sel,
    input  logic [DATA_W-1:0] acc,
    input  logic [CHAR_W-1:0] in_char,
    input  logic              in_strobe,
    input  logic              out_done,
    input  logic              irq_done,
    output acc_upd_t          upd,
    output logic              skip,
    output logic              in_flag,
    output logic              out_flag,
    output logic              ien,
    output logic [CHAR_W-1:0] out_char
);

    logic do_in, do_out, do_on, do_off;

    assign do_in  = go & sel[IB_IN];
    assign do_out = go & sel[IB_OUT];
    assign do_on  = go & sel[IB_ION];
    assign do_off = go & sel[IB_IOF];

    always_ff @(posedge clk) begin
        if (rst) begin
            in_flag  <= 1'b0;
            out_flag <= 1'b0;
            ien      <= 1'b0;
            out_char <= '0;
        end else begin
            if (in_strobe)   in_flag <= 1'b1;
            else if (do_in)  in_flag <= 1'b0;

            if (out_done)    out_flag <= 1'b1;
            else if (do_out) out_flag <= 1'b0;

            if (do_out) out_char <= acc[CHAR_W-1:0];

            if (irq_done)    ien <= 1'b0;
            else if (do_on)  ien <= 1'b1;
            else if (do_off) ien <= 1'b0;
        end
    end

    always_comb begin
        upd.acc    = {acc[DATA_W-1:CHAR_W], in_char};
        upd.e      = 1'b0;
        upd.acc_wr = do_in;
        upd.e_wr   = 1'b0;
    end

    assign skip = go & ((sel[IB_SKI] & in_flag) | (sel[IB_SKO] & out_flag));

    // R7: the input-ready flag only drops after an input instruction
    a_r7_in_flag_drop: assert property (@(posedge clk) disable iff (rst)
        $fell(in_flag) |-> $past(do_in));

    // R10: enable only rises after an enable instruction
    a_r10_ien_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(ien) |-> $past(do_on));

    // R8: a device strobe always leaves its flag set
    a_r8_strobe_sets: assert property (@(posedge clk) disable iff (rst)
        out_done |=> out_flag);

endmodule

// File: rtl/accum_irq_seq.sv
module accum_irq_seq
    import accum_regio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [STEP_W-1:0] step,
    input  logic              ien,
    input  logic              in_flag,
    input  logic              out_flag,
    output logic              irq_req,
    output logic              ar_clr,
    output logic              tr_ld_pc,
    output logic              mem_wr,
    output logic              pc_clr,
    output logic              irq_done
);

    logic early_step;
    logic set_req;

    assign early_step = (step == STEP_W'(0)) || (step == STEP_W'(1)) ||
                        (step == STEP_W'(2));
    assign set_req    = !early_step && ien && (in_flag || out_flag);

    assign ar_clr   = irq_req && (step == STEP_W'(0));
    assign tr_ld_pc = irq_req && (step == STEP_W'(0));
    assign mem_wr   = irq_req && (step == STEP_W'(1));
    assign pc_clr   = irq_req && (step == STEP_W'(1));
    assign irq_done = irq_req && (step == STEP_W'(2));

    always_ff @(posedge clk) begin
        if (rst)           irq_req <= 1'b0;
        else if (irq_done) irq_req <= 1'b0;
        else if (set_req)  irq_req <= 1'b1;
    end

    // R11: request only rises after a late step with interrupts enabled
    a_r11_req_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_req) |-> ($past(ien) && ($past(step) > STEP_W'(2))));

    // R12: the last entry step always retires the request
    a_r12_req_exit: assert property (@(posedge clk) disable iff (rst)
        (irq_req && step == STEP_W'(2)) |=> !irq_req);

    // R12: entry steps never overlap
    a_r12_steps_apart: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ar_clr, mem_wr, irq_done}));

endmodule

// File: rtl/accum_regio_ctrl.sv
module accum_regio_ctrl
    import accum_regio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] ir_word,
    input  logic [STEP_W-1:0] step,
    input  logic [DATA_W-1:0] acc_in,
    input  logic              e_in,
    input  logic [CHAR_W-1:0] in_char,
    input  logic              in_strobe,
    input  logic              out_done,
    output logic [DATA_W-1:0] acc_nxt,
    output logic              acc_wr,
    output logic              e_nxt,
    output logic              e_wr,
    output logic              pc_inc,
    output logic              seq_clr,
    output logic              ar_clr,
    output logic              tr_ld_pc,
    output logic              mem_wr,
    output logic              pc_clr,
    output logic [CHAR_W-1:0] out_char,
    output logic              in_flag,
    output logic              out_flag,
    output logic              irq_en,
    output logic              irq_req,
    output logic              halted
);

    instr_cls_e cls;
    logic       exec_ok, reg_go, dev_go;
    acc_upd_t   reg_upd, dev_upd;
    logic       reg_skip, dev_skip, halt_req, irq_done;

    assign cls     = classify(ir_word);
    assign exec_ok = (step == STEP_W'(EXEC_STEP)) && !halted && !irq_req;
    assign reg_go  = exec_ok && (cls == CLS_REG);
    assign dev_go  = exec_ok && (cls == CLS_DEV);

    accum_regop_unit u_regop (
        .clk      (clk),
        .rst      (rst),
        .go       (reg_go),
        .ops      (ir_word[OPS_W-1:0]),
        .acc      (acc_in),
        .e        (e_in),
        .upd      (reg_upd),
        .skip     (reg_skip),
        .halt_req (halt_req)
    );

    accum_io_unit u_io (
        .clk       (clk),
        .rst       (rst),
        .go        (dev_go),
        .sel       (ir_word[OPS_W-1:IO_BASE]),
        .acc       (acc_in),
        .in_char   (in_char),
        .in_strobe (in_strobe),
        .out_done  (out_done),
        .irq_done  (irq_done),
        .upd       (dev_upd),
        .skip      (dev_skip),
        .in_flag   (in_flag),
        .out_flag  (out_flag),
        .ien       (irq_en),
        .out_char  (out_char)
    );

    accum_irq_seq u_irq (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .ien      (irq_en),
        .in_flag  (in_flag),
        .out_flag (out_flag),
        .irq_req  (irq_req),
        .ar_clr   (ar_clr),
        .tr_ld_pc (tr_ld_pc),
        .mem_wr   (mem_wr),
        .pc_clr   (pc_clr),
        .irq_done (irq_done)
    );

    always_ff @(posedge clk) begin
        if (rst)           halted <= 1'b0;
        else if (halt_req) halted <= 1'b1;
    end

    assign acc_nxt = reg_go ? reg_upd.acc : dev_upd.acc;
    assign acc_wr  = reg_upd.acc_wr | dev_upd.acc_wr;
    assign e_nxt   = reg_go ? reg_upd.e : dev_upd.e;
    assign e_wr    = reg_upd.e_wr | dev_upd.e_wr;
    assign pc_inc  = reg_skip | dev_skip | irq_done;
    assign seq_clr = reg_go | dev_go | irq_done;

    // R6: halt is sticky until reset
    a_r6_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    // R6: a halted machine writes nothing
    a_r6_halt_quiet: assert property (@(posedge clk) disable iff (rst)
        (halted && !irq_req) |-> !(acc_wr || e_wr || seq_clr));

    // R5: every skip ends the instruction
    a_r5_skip_ends: assert property (@(posedge clk) disable iff (rst)
        pc_inc |-> seq_clr);

endmodule

// File: tb/accum_regio_ctrl_tb.sv
module accum_regio_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] ir_word = '0;
    logic [3:0]  step = '0;
    logic [15:0] acc_in = '0;
    logic        e_in = 1'b0;
    logic [7:0]  in_char = '0;
    logic        in_strobe = 1'b0;
    logic        out_done = 1'b0;
    logic [15:0] acc_nxt;
    logic        acc_wr, e_nxt, e_wr, pc_inc, seq_clr;
    logic        ar_clr, tr_ld_pc, mem_wr, pc_clr;
    logic [7:0]  out_char;
    logic        in_flag, out_flag, irq_en, irq_req, halted;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    accum_regio_ctrl u_dut (
        .clk(clk), .rst(rst), .ir_word(ir_word), .step(step), .acc_in(acc_in),
        .e_in(e_in), .in_char(in_char), .in_strobe(in_strobe), .out_done(out_done),
        .acc_nxt(acc_nxt), .acc_wr(acc_wr), .e_nxt(e_nxt), .e_wr(e_wr),
        .pc_inc(pc_inc), .seq_clr(seq_clr), .ar_clr(ar_clr), .tr_ld_pc(tr_ld_pc),
        .mem_wr(mem_wr), .pc_clr(pc_clr), .out_char(out_char), .in_flag(in_flag),
        .out_flag(out_flag), .irq_en(irq_en), .irq_req(irq_req), .halted(halted)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive inputs half a period before the edge, sample shortly after
    task automatic put(input logic [15:0] w, input logic [3:0] s,
                       input logic [15:0] a, input logic e);
        @(negedge clk);
        ir_word = w; step = s; acc_in = a; e_in = e;
        #2;
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // expected AC for a single register-class bit k
    function automatic logic [15:0] ref_acc(input int k, input logic [15:0] a,
                                            input logic e);
        case (k)
            11: return 16'h0000;
            9:  return ~a;
            7:  return {e, a[15:1]};
            6:  return {a[14:0], e};
            5:  return a + 16'h1;
            default: return a;
        endcase
    endfunction

    function automatic logic ref_e(input int k, input logic [15:0] a, input logic e);
        case (k)
            10: return 1'b0;
            8:  return ~e;
            7:  return a[0];
            6:  return a[15];
            default: return e;
        endcase
    endfunction

    function automatic logic ref_awr(input int k);
        return (k == 11) || (k == 9) || (k == 7) || (k == 6) || (k == 5);
    endfunction

    function automatic logic ref_ewr(input int k);
        return (k == 10) || (k == 8) || (k == 7) || (k == 6);
    endfunction

    function automatic logic ref_skip(input int k, input logic [15:0] a, input logic e);
        case (k)
            4: return !a[15];
            3: return a[15];
            2: return a == 16'h0;
            1: return !e;
            default: return 1'b0;
        endcase
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] a;
        logic        e;
        void'($urandom(32'h1D5));

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        // R13 reset state
        chk("R13 halted", halted, 0);
        chk("R13 irq_en", irq_en, 0);
        chk("R13 irq_req", irq_req, 0);
        chk("R13 in_flag", in_flag, 0);
        chk("R13 out_flag", out_flag, 0);
        chk("R13 out_char", out_char, 8'h00);

        // R1 wrong opcode or wrong step does nothing
        put(16'h3800, 4'd3, 16'h1234, 1'b0);
        chk("R1 other opcode acc_wr", acc_wr, 0);
        chk("R1 other opcode seq_clr", seq_clr, 0);
        put(16'h7800, 4'd4, 16'h1234, 1'b0);
        chk("R1 wrong step acc_wr", acc_wr, 0);
        chk("R1 wrong step seq_clr", seq_clr, 0);
        put(16'h7800, 4'd3, 16'h1234, 1'b0);
        chk("R1 executes seq_clr", seq_clr, 1);

        // R2..R5 random one-hot register words (halt excluded)
        for (int i = 0; i < 300; i++) begin
            int k;
            k = int'($urandom_range(1, 11));
            a = 16'($urandom);
            if (i % 6 == 0) a = 16'h0000;
            e = 1'($urandom);
            put(16'h7000 | 16'(1 << k), 4'd3, a, e);
            chk("R2-5 acc_wr", acc_wr, ref_awr(k));
            chk("R2-5 e_wr", e_wr, ref_ewr(k));
            if (ref_awr(k)) chk("R2 R3 R4 acc_nxt", acc_nxt, ref_acc(k, a, e));
            if (ref_ewr(k)) chk("R2 R3 e_nxt", e_nxt, ref_e(k, a, e));
            chk("R5 pc_inc", pc_inc, ref_skip(k, a, e));
            chk("R1 seq_clr", seq_clr, 1);
        end

        // directed corners
        put(16'h7020, 4'd3, 16'hFFFF, 1'b1);
        chk("R4 inc wraps", acc_nxt, 16'h0000);
        chk("R4 e untouched", e_wr, 0);
        put(16'h7080, 4'd3, 16'h0001, 1'b0);
        chk("R3 rot right acc", acc_nxt, 16'h0000);
        chk("R3 rot right e", e_nxt, 1);
        put(16'h7040, 4'd3, 16'h8000, 1'b1);
        chk("R3 rot left acc", acc_nxt, 16'h0001);
        chk("R3 rot left e", e_nxt, 1);
        put(16'h7010, 4'd3, 16'h0000, 1'b0);
        chk("R5 zero counts as positive", pc_inc, 1);
        put(16'h7004, 4'd3, 16'h0000, 1'b1);
        chk("R5 skip on zero", pc_inc, 1);

        // R9 / R8 input flag
        put(16'hF200, 4'd3, 16'h0000, 1'b0);
        chk("R9 no skip when input empty", pc_inc, 0);
        @(negedge clk); ir_word = 16'h0000; step = 4'd0; in_strobe = 1'b1;
        tick();
        @(negedge clk); in_strobe = 1'b0; #2;
        chk("R8 in_strobe sets flag", in_flag, 1);
        put(16'hF200, 4'd3, 16'h0000, 1'b0);
        chk("R9 skip on input ready", pc_inc, 1);

        // R7 input instruction
        in_char = 8'hA5;
        put(16'hF800, 4'd3, 16'h1234, 1'b0);
        chk("R7 input into low byte", acc_nxt, 16'h12A5);
        chk("R7 input acc_wr", acc_wr, 1);
        chk("R7 input seq_clr", seq_clr, 1);
        tick();
        chk("R7 input clears flag", in_flag, 0);

        // R8 / R9 / R7 output path
        @(negedge clk); ir_word = 16'h0000; step = 4'd0; out_done = 1'b1;
        tick();
        @(negedge clk); out_done = 1'b0; #2;
        chk("R8 out_done sets flag", out_flag, 1);
        put(16'hF100, 4'd3, 16'h0000, 1'b0);
        chk("R9 skip on output ready", pc_inc, 1);
        put(16'hF400, 4'd3, 16'h77C3, 1'b0);
        chk("R7 output no acc write", acc_wr, 0);
        tick();
        chk("R7 output char", out_char, 8'hC3);
        chk("R7 output clears flag", out_flag, 0);

        // R10 enable on/off with both flags clear
        put(16'hF080, 4'd3, 16'h0000, 1'b0);
        tick();
        chk("R10 enable set", irq_en, 1);
        put(16'hF040, 4'd3, 16'h0000, 1'b0);
        tick();
        chk("R10 enable cleared", irq_en, 0);
        put(16'hF080, 4'd3, 16'h0000, 1'b0);
        tick();
        chk("R10 enable set again", irq_en, 1);
        put(16'h0000, 4'd4, 16'h0000, 1'b0);
        tick();
        chk("R11 no request without flag", irq_req, 0);

        // R8 strobe wins over a same-cycle input instruction
        @(negedge clk); ir_word = 16'hF800; step = 4'd3; in_strobe = 1'b1;
        tick();
        @(negedge clk); in_strobe = 1'b0; ir_word = 16'h0000; step = 4'd0; #2;
        chk("R8 strobe wins over clear", in_flag, 1);
        tick();
        chk("R11 step 0 never requests", irq_req, 0);
        put(16'h0000, 4'd4, 16'h0000, 1'b0);
        tick();
        chk("R11 request raised", irq_req, 1);

        // R12 entry sequence
        put(16'h7800, 4'd0, 16'h0000, 1'b0);
        chk("R12 step0 ar_clr", ar_clr, 1);
        chk("R12 step0 tr_ld_pc", tr_ld_pc, 1);
        chk("R12 step0 no mem_wr", mem_wr, 0);
        put(16'h0000, 4'd1, 16'h0000, 1'b0);
        chk("R12 step1 mem_wr", mem_wr, 1);
        chk("R12 step1 pc_clr", pc_clr, 1);
        put(16'h0000, 4'd2, 16'h0000, 1'b0);
        chk("R12 step2 pc_inc", pc_inc, 1);
        chk("R12 step2 seq_clr", seq_clr, 1);
        tick();
        chk("R12 request retired", irq_req, 0);
        chk("R12 enable cleared", irq_en, 0);

        // R6 halt
        put(16'h7001, 4'd3, 16'h0000, 1'b0);
        chk("R6 halt word ends instruction", seq_clr, 1);
        tick();
        chk("R6 halted set", halted, 1);
        put(16'h7800, 4'd3, 16'h1111, 1'b0);
        chk("R6 no exec while halted acc_wr", acc_wr, 0);
        chk("R6 no exec while halted seq_clr", seq_clr, 0);
        tick();
        chk("R6 halted stays", halted, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule